// File: doc/BRIEF.md
# Multi-Channel Gamma Correction Table

This block applies gamma correction to 24-bit pixels on several display channels at once. Every channel has three 256-entry, 8-bit tables, one each for red, green and blue. All of the tables sit in one flat memory. Each channel owns a run of three consecutive tables, in the order red, green, blue, and the channels follow one another by index.

A host loads the memory through a small two-register style port. One strobe sets a start address together with an auto-increment flag. Each data strobe after that stores one 8-bit entry. When auto-increment is set, the address moves forward by one after each stored entry. To reload one channel, the host sets the address to channel × 768 with auto-increment on, then streams 768 entries.

On the pixel side, each channel has its own valid, horizontal sync and vertical sync inputs and its own 24-bit pixel. A registered lookup produces the corrected pixel one clock later. The sideband signals are delayed by the same clock, so they stay aligned with the data. A per-channel enable chooses between the corrected pixel and the unchanged input pixel, and both choices have the same latency. Software should reload the tables after it re-enables correction on a system where every channel had correction turned off, because the storage may have been powered down in that state.

Top module: `gamma_lut`

## Requirements
- R1: After reset, every table holds the identity mapping: entry i holds i. With the enable set, every pixel comes out unchanged.
- R2: The table entry for channel c, colour k (0 red, 1 green, 2 blue) and input value v lives at address c*768 + k*256 + v. The pixel fields are red in bits [23:16], green in [15:8] and blue in [7:0]. Channel c uses pixel bits [c*24 +: 24].
- R3: When the auto-increment flag latched with the last address load is 1, each data strobe stores cfg_data at the current address and then advances the address by one.
- R4: When the latched auto-increment flag is 0, each data strobe writes the same address, and the address does not change.
- R5: When auto-increment is on, a data strobe at the last address (NUM_CH*768-1) moves the address to 0. A data strobe at an address beyond the memory stores nothing and also moves the address to 0.
- R6: Corrected data and the valid, hsync and vsync outputs of each channel appear exactly one clock after the matching inputs. After reset they are 0.
- R7: When a channel's gamma enable is 0, its input pixel reaches the output unchanged, with the same one-clock latency.
- R8: Each channel's lookup uses only its own three tables. Loading one channel's tables does not change the output of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_we | input | 1 | Loads the start address and the auto-increment flag |
| cfg_addr | input | ADDR_W | Start address |
| cfg_autoinc | input | 1 | Auto-increment flag, latched with the address |
| cfg_data_we | input | 1 | Stores one table entry |
| cfg_data | input | COMP_W | Table entry value |
| gamma_en | input | NUM_CH | Per-channel correction enable |
| pix_valid_i | input | NUM_CH | Per-channel pixel valid |
| pix_hs_i | input | NUM_CH | Per-channel horizontal sync |
| pix_vs_i | input | NUM_CH | Per-channel vertical sync |
| pix_data_i | input | NUM_CH*3*COMP_W | Per-channel input pixels |
| pix_valid_o | output | NUM_CH | Delayed valid |
| pix_hs_o | output | NUM_CH | Delayed horizontal sync |
| pix_vs_o | output | NUM_CH | Delayed vertical sync |
| pix_data_o | output | NUM_CH*3*COMP_W | Corrected or bypassed pixels |

## Verification
Some behaviours are checked on every cycle by the assertions. These are the load-pointer behaviour (loading, stepping, holding and wrapping), the one-clock delay of the sideband signals, and the unchanged bypass path on channels whose enable is off. Other behaviours can only be shown by the bench scenarios, which write known patterns and then probe pixels. These are that the contents match the identity at reset, that the channel, colour and value layout of the memory is right, that a write without auto-increment overwrites the same entry and leaves its neighbour alone, that the wrap lands in channel 0 red, and that the channels stay isolated from each other.

// File: rtl/gamma_lut.sv
module gamma_lut #(
  parameter int NUM_CH = 3,
  parameter int COMP_W = 8,
  parameter int ADDR_W = $clog2(NUM_CH * 3 * (1 << COMP_W))
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_addr_we,
  input  logic [ADDR_W-1:0]            cfg_addr,
  input  logic                         cfg_autoinc,
  input  logic                         cfg_data_we,
  input  logic [COMP_W-1:0]            cfg_data,
  input  logic [NUM_CH-1:0]            gamma_en,
  input  logic [NUM_CH-1:0]            pix_valid_i,
  input  logic [NUM_CH-1:0]            pix_hs_i,
  input  logic [NUM_CH-1:0]            pix_vs_i,
  input  logic [NUM_CH*3*COMP_W-1:0]   pix_data_i,
  output logic [NUM_CH-1:0]            pix_valid_o,
  output logic [NUM_CH-1:0]            pix_hs_o,
  output logic [NUM_CH-1:0]            pix_vs_o,
  output logic [NUM_CH*3*COMP_W-1:0]   pix_data_o
);
  localparam int TBL   = 1 << COMP_W;
  localparam int DEPTH = NUM_CH * 3 * TBL;
  localparam int PIX_W = 3 * COMP_W;

  logic [COMP_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic              inc_q;
  logic              in_range, at_end;

  assign in_range = 32'(addr_q) < DEPTH;
  assign at_end   = 32'(addr_q) >= DEPTH - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      inc_q  <= 1'b0;
    end else if (cfg_addr_we) begin
      addr_q <= cfg_addr;
      inc_q  <= cfg_autoinc;
    end else if (cfg_data_we && inc_q) begin
      addr_q <= at_end ? '0 : addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= COMP_W'(i % TBL);
    end else if (cfg_data_we && in_range) begin
      mem[addr_q] <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid_o <= '0;
      pix_hs_o    <= '0;
      pix_vs_o    <= '0;
    end else begin
      pix_valid_o <= pix_valid_i;
      pix_hs_o    <= pix_hs_i;
      pix_vs_o    <= pix_vs_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PIX_W-1:0] px, lut_px, out_q;
    assign px = pix_data_i[c*PIX_W +: PIX_W];

    for (genvar k = 0; k < 3; k++) begin : g_col
      localparam int BASE = (c * 3 + k) * TBL;
      assign lut_px[(2-k)*COMP_W +: COMP_W] =
        mem[ADDR_W'(BASE) + ADDR_W'(px[(2-k)*COMP_W +: COMP_W])];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= gamma_en[c] ? lut_px : px;
    end

    assign pix_data_o[c*PIX_W +: PIX_W] = out_q;
  end
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int NUM_CH = 3,
  parameter int COMP_W = 8,
  parameter int ADDR_W = 12
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_addr_we,
  input logic [ADDR_W-1:0]            cfg_addr,
  input logic                         cfg_autoinc,
  input logic                         cfg_data_we,
  input logic [ADDR_W-1:0]            addr_q,
  input logic                         inc_q,
  input logic [NUM_CH-1:0]            gamma_en,
  input logic [NUM_CH-1:0]            pix_valid_i,
  input logic [NUM_CH-1:0]            pix_hs_i,
  input logic [NUM_CH-1:0]            pix_vs_i,
  input logic [NUM_CH*3*COMP_W-1:0]   pix_data_i,
  input logic [NUM_CH-1:0]            pix_valid_o,
  input logic [NUM_CH-1:0]            pix_hs_o,
  input logic [NUM_CH-1:0]            pix_vs_o,
  input logic [NUM_CH*3*COMP_W-1:0]   pix_data_o
);
  localparam int DEPTH = NUM_CH * 3 * (1 << COMP_W);
  localparam int PIX_W = 3 * COMP_W;

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr_we |=> addr_q == $past(cfg_addr) && inc_q == $past(cfg_autoinc)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_addr_we && cfg_data_we && inc_q && 32'(addr_q) < DEPTH - 1
    |=> addr_q == $past(addr_q) + 1'b1); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_addr_we && cfg_data_we && !inc_q |=> $stable(addr_q)); // R4

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_addr_we && cfg_data_we && inc_q && 32'(addr_q) >= DEPTH - 1
    |=> addr_q == '0); // R5

  AST_SIDEBAND_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> pix_valid_o == $past(pix_valid_i) && pix_hs_o == $past(pix_hs_i)
             && pix_vs_o == $past(pix_vs_i)); // R6

  for (genvar c = 0; c < NUM_CH; c++) begin : g_byp
    AST_BYPASS_SAME_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !$past(gamma_en[c])
      |-> pix_data_o[c*PIX_W +: PIX_W] == $past(pix_data_i[c*PIX_W +: PIX_W])); // R7
  end
endmodule

bind gamma_lut gamma_lut_chk #(.NUM_CH(NUM_CH), .COMP_W(COMP_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_gamma_lut.sv
module test_gamma_lut;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam int COMP_W = 8;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = NUM_CH * 768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_addr_we = 1'b0, cfg_autoinc = 1'b0, cfg_data_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic [NUM_CH-1:0] gamma_en = '1;
  logic [NUM_CH-1:0] pix_valid_i = '0, pix_hs_i = '0, pix_vs_i = '0;
  logic [NUM_CH*24-1:0] pix_data_i = '0;
  logic [NUM_CH-1:0] pix_valid_o, pix_hs_o, pix_vs_o;
  logic [NUM_CH*24-1:0] pix_data_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] model [DEPTH];
  int m_addr = 0;
  bit m_inc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_lut #(.NUM_CH(NUM_CH), .COMP_W(COMP_W)) i_gamma_lut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_px(input int c, input logic [23:0] px);
    if (!gamma_en[c]) return px;
    return {model[c*768 + px[23:16]], model[c*768 + 256 + px[15:8]],
            model[c*768 + 512 + px[7:0]]};
  endfunction

  task automatic set_addr(input int a, input bit inc);
    cfg_addr_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_autoinc = inc;
    @(negedge clk);
    cfg_addr_we = 1'b0;
    m_addr = a; m_inc = inc;
  endtask

  task automatic put(input logic [7:0] d);
    cfg_data_we = 1'b1; cfg_data = d;
    @(negedge clk);
    cfg_data_we = 1'b0;
    if (m_addr < DEPTH) model[m_addr] = d;
    if (m_inc) m_addr = (m_addr >= DEPTH - 1) ? 0 : m_addr + 1;
  endtask

  task automatic probe(input int c, input logic [23:0] px, input string req);
    logic [23:0] exp;
    exp = expect_px(c, px);
    pix_data_i[c*24 +: 24] = px;
    pix_valid_i[c] = 1'b1;
    @(negedge clk);
    chk(req, {8'h0, pix_data_o[c*24 +: 24]}, {8'h0, exp});
    chk(req, pix_valid_o[c], 1);
    pix_valid_i[c] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R6 reset valid", pix_valid_o, 0);
    chk("R6 reset data", pix_data_o[31:0], 0);
    probe(0, 24'h123456, "R1 identity ch0");
    probe(2, 24'hFF00A5, "R1 identity ch2");
  endtask

  task automatic t_load_channel;
    set_addr(1 * 768, 1'b1);
    for (int i = 0; i < 256; i++) put(8'(255 - i));
    for (int i = 0; i < 256; i++) put(8'(i) ^ 8'h5A);
    for (int i = 0; i < 256; i++) put(8'(i * 7));
    probe(1, 24'h000000, "R2 ch1 layout low");
    probe(1, 24'h10FF80, "R3 ch1 autoinc fill");
    probe(1, 24'hFF0133, "R2 ch1 layout high");
    probe(0, 24'h10FF80, "R8 ch0 untouched");
    probe(2, 24'h10FF80, "R8 ch2 untouched");
  endtask

  task automatic t_no_increment;
    set_addr(256 + 8'h10, 1'b0);
    put(8'hAA);
    put(8'hBB);
    probe(0, 24'h001000, "R4 same entry overwritten");
    probe(0, 24'h001100, "R4 neighbour unchanged");
  endtask

  task automatic t_wrap;
    set_addr(DEPTH - 1, 1'b1);
    put(8'h77);
    put(8'h66);
    probe(2, 24'h0000FF, "R5 last entry written");
    probe(0, 24'h000000, "R5 wrapped to zero");
    set_addr(4000, 1'b1);
    put(8'h99);
    put(8'h55);
    probe(0, 24'h000000, "R5 out of range wraps");
  endtask

  task automatic t_bypass;
    gamma_en[1] = 1'b0;
    probe(1, 24'h10FF80, "R7 bypass unchanged");
    gamma_en[1] = 1'b1;
    probe(1, 24'h10FF80, "R7 enable restored");
  endtask

  task automatic t_sideband;
    pix_data_i[2*24 +: 24] = 24'h0102FF;
    pix_valid_i[2] = 1'b1; pix_hs_i[2] = 1'b1; pix_vs_i[2] = 1'b1;
    #1;
    chk("R6 no early valid", pix_valid_o[2], 0);
    @(negedge clk);
    pix_valid_i[2] = 1'b0; pix_hs_i[2] = 1'b0; pix_vs_i[2] = 1'b0;
    chk("R6 hs delayed", pix_hs_o[2], 1);
    chk("R6 vs delayed", pix_vs_o[2], 1);
    chk("R6 data aligned", {8'h0, pix_data_o[2*24 +: 24]}, {8'h0, expect_px(2, 24'h0102FF)});
    @(negedge clk);
    chk("R6 sideband drops", {pix_valid_o[2], pix_hs_o[2], pix_vs_o[2]}, 0);
  endtask

  task automatic t_all_channels;
    logic [23:0] px [NUM_CH];
    px[0] = 24'h102030; px[1] = 24'h405060; px[2] = 24'h70FF00;
    for (int c = 0; c < NUM_CH; c++) pix_data_i[c*24 +: 24] = px[c];
    pix_valid_i = '1;
    @(negedge clk);
    for (int c = 0; c < NUM_CH; c++)
      chk("R8 parallel channels", {8'h0, pix_data_o[c*24 +: 24]}, {8'h0, expect_px(c, px[c])});
    pix_valid_i = '0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'(i % 256);
    repeat (3) @(negedge clk);
    t_reset_pre: chk("R6 held in reset", pix_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load_channel;
    t_no_increment;
    t_wrap;
    t_bypass;
    t_sideband;
    t_all_channels;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule